// File: doc/BRIEF.md
# SPI Master Word Serialiser with Inter-Word Gap

This block is the shift engine of an SPI master. It accepts parallel words through a valid/ready handshake and serialises each one on `sck_o` and `mosi_o`. At the same time it captures `miso_i` into a receive word, which is presented with a one-cycle valid pulse. It runs entirely on a single source clock. SCK is derived from that clock by a programmable prescaler.

Polarity, phase and the number of valid bits per word are set on configuration inputs. The first bit of each word goes out most-significant first. After every word the engine holds off the next word for a programmable idle gap, counted in source-clock cycles. A word that is already waiting is taken on the last cycle of that gap, so words sent back-to-back keep exactly the gap spacing.

Top module: `spi_word_engine`

## Requirements
- R1: While a word shifts, `sck_o` holds each level for exactly `cfg_prescale_i`+1 source cycles. A prescale of 0 gives SCK at half the source clock. The first level change comes `cfg_prescale_i`+1 cycles after the accepting clock edge.
- R2: Whenever no word is shifting (reset, gap, idle), `sck_o` equals `cfg_cpol_i`. The value 0 means idle low and 1 means idle high.
- R3: Phase selects the sampling edge. With `cfg_cpha_i`=0, `miso_i` is sampled on the odd-numbered SCK edges (1st, 3rd, ...). With `cfg_cpha_i`=1, it is sampled on the even-numbered edges.
- R4: A word of N bits makes exactly 2N SCK edges. N is `cfg_bits_i`, and the value 0 means 32. `mosi_o` carries bit N-1 of the word first and then the lower bits in order. With `cfg_cpha_i`=0, `mosi_o` moves to the next bit on even edges. With `cfg_cpha_i`=1, it moves on odd edges from the 3rd on.
- R5: The N sampled bits are output right-aligned on `rx_data_o`, first sample in bit N-1 and upper bits zero. `rx_valid_o` is high for exactly one cycle, the cycle after the final SCK edge.
- R6: After the final SCK edge, a gap of 4·`cfg_gap_i`+10 source cycles follows. `tx_ready_o` is low in all of these cycles except the last. A word offered in that last cycle starts shifting in the next cycle.
- R7: `busy_o` is high from the cycle after acceptance through the cycle ending with the final SCK edge. `tx_ready_o` is never high while `busy_o` is high.
- R8: Prescale, gap, bit count, phase and data are captured when a word is accepted. Changing those inputs while the word runs has no effect on that word.
- R9: In reset, `busy_o`=0, `tx_ready_o`=1, `rx_valid_o`=0 and `sck_o`=`cfg_cpol_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_prescale_i | input | PRE_W | SCK half-period minus one, in source cycles |
| cfg_gap_i | input | GAP_W | Gap field; gap = 4·value+10 cycles |
| cfg_bits_i | input | 5 | Valid bits per word, 0 means 32 |
| cfg_cpol_i | input | 1 | SCK idle level |
| cfg_cpha_i | input | 1 | Sample on second edge of each bit when 1 |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_data_i | input | DW | Transmit word, right-aligned |
| tx_ready_o | output | 1 | Word accepted when high with tx_valid_i |
| rx_valid_o | output | 1 | Received word present, one cycle |
| rx_data_o | output | DW | Received word, right-aligned |
| busy_o | output | 1 | Word shifting |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest case to reach is a word accepted on the single last cycle of a gap, since `tx_ready_o` is high there for only that one cycle. The stimulus keeps `tx_valid_i` high across bursts of two and three words, so acceptance must land exactly on that cycle. A second hard case is a configuration change in the middle of a word. The bench changes prescale, bit count, gap and phase while the engine is busy, and still expects the timing of the captured settings. A behavioural model indexed by the cycles since acceptance predicts every output on every cycle. It covers gap fields 0, 1, 2, 3 and 31, and word lengths 1, 5, 8, 16 and 32.

// File: rtl/spi_we_pkg.sv
package spi_we_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} st_e;
endpackage

// File: rtl/spi_we_sckgen.sv
module spi_we_sckgen #(
  parameter int PRE_W = 8,
  parameter int EC_W  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             edge_o,
  output logic [EC_W-1:0]  edge_cnt_o,
  output logic             tog_o
);
  logic [PRE_W-1:0] pre_q, div_q;
  logic [EC_W-1:0]  ec_q;
  logic             tog_q;

  assign edge_o     = run_i && (div_q == pre_q);
  assign edge_cnt_o = ec_q;
  assign tog_o      = tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      div_q <= '0;
      ec_q  <= '0;
      tog_q <= 1'b0;
    end else if (start_i) begin
      pre_q <= pre_i;
      div_q <= '0;
      ec_q  <= '0;
      tog_q <= 1'b0;
    end else if (edge_o) begin
      div_q <= '0;
      ec_q  <= ec_q + EC_W'(1);
      tog_q <= ~tog_q;
    end else if (run_i) begin
      div_q <= div_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/spi_we_shifter.sv
module spi_we_shifter #(
  parameter int DW   = 32,
  parameter int NB_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [DW-1:0]   word_i,
  input  logic [NB_W-1:0] nbits_i,
  input  logic            edge_i,
  input  logic            lead_i,
  input  logic            first_i,
  input  logic            cpha_i,
  input  logic            miso_i,
  output logic            mosi_o,
  output logic [DW-1:0]   rx_o
);
  logic [DW-1:0]   tx_sr, rx_sr;
  logic [NB_W-1:0] sh_amt;
  logic            sample, advance;

  // left-justify so the word MSB sits at the output bit
  assign sh_amt  = NB_W'(DW) - nbits_i;
  assign sample  = edge_i && (cpha_i ? !lead_i : lead_i);
  assign advance = edge_i && (cpha_i ? (lead_i && !first_i) : !lead_i);
  assign mosi_o  = tx_sr[DW-1];
  assign rx_o    = rx_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else if (start_i) begin
      tx_sr <= word_i << sh_amt;
      rx_sr <= '0;
    end else begin
      if (advance) tx_sr <= {tx_sr[DW-2:0], 1'b0};
      if (sample)  rx_sr <= {rx_sr[DW-2:0], miso_i};
    end
  end
endmodule

// File: rtl/spi_we_gap.sv
module spi_we_gap #(
  parameter int GAP_W = 5,
  localparam int CNT_W = GAP_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= CNT_W'({gap_i, 2'b00}) + CNT_W'(9);
    else if (run_i && !zero_o)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
  import spi_we_pkg::*;
#(
  parameter int DW    = 32,
  parameter int PRE_W = 8,
  parameter int GAP_W = 5,
  localparam int BITS_W = $clog2(DW),
  localparam int NB_W   = $clog2(DW + 1),
  localparam int EC_W   = NB_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRE_W-1:0]  cfg_prescale_i,
  input  logic [GAP_W-1:0]  cfg_gap_i,
  input  logic [BITS_W-1:0] cfg_bits_i,
  input  logic              cfg_cpol_i,
  input  logic              cfg_cpha_i,
  input  logic              tx_valid_i,
  input  logic [DW-1:0]     tx_data_i,
  output logic              tx_ready_o,
  output logic              rx_valid_o,
  output logic [DW-1:0]     rx_data_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  st_e              st_q, st_d;
  logic [NB_W-1:0]  n_cur, n_q;
  logic [GAP_W-1:0] gap_q;
  logic             cpha_q, rx_valid_q;
  logic             accept, sck_edge, tog, last_edge, gap_zero, gap_last;
  logic [EC_W-1:0]  edge_cnt;

  assign n_cur      = (cfg_bits_i == '0) ? NB_W'(DW) : NB_W'(cfg_bits_i);
  assign gap_last   = (st_q == ST_GAP) && gap_zero;
  assign tx_ready_o = (st_q == ST_IDLE) || gap_last;
  assign accept     = tx_valid_i && tx_ready_o;
  assign last_edge  = sck_edge && ((edge_cnt + EC_W'(1)) == {n_q, 1'b0});
  assign busy_o     = (st_q == ST_SHIFT);
  assign sck_o      = cfg_cpol_i ^ tog;
  assign rx_valid_o = rx_valid_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_SHIFT;
      ST_SHIFT: if (last_edge) st_d = ST_GAP;
      ST_GAP:   if (gap_last) st_d = accept ? ST_SHIFT : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      n_q        <= NB_W'(1);
      gap_q      <= '0;
      cpha_q     <= 1'b0;
      rx_valid_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      rx_valid_q <= last_edge;
      if (accept) begin
        n_q    <= n_cur;
        gap_q  <= cfg_gap_i;
        cpha_q <= cfg_cpha_i;
      end
    end
  end

  spi_we_sckgen #(.PRE_W(PRE_W), .EC_W(EC_W)) i_sckgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .run_i      (busy_o),
    .pre_i      (cfg_prescale_i),
    .edge_o     (sck_edge),
    .edge_cnt_o (edge_cnt),
    .tog_o      (tog)
  );

  spi_we_shifter #(.DW(DW), .NB_W(NB_W)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .word_i  (tx_data_i),
    .nbits_i (n_cur),
    .edge_i  (sck_edge),
    .lead_i  (!edge_cnt[0]),
    .first_i (edge_cnt == '0),
    .cpha_i  (cpha_q),
    .miso_i  (miso_i),
    .mosi_o  (mosi_o),
    .rx_o    (rx_data_o)
  );

  spi_we_gap #(.GAP_W(GAP_W)) i_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (last_edge),
    .run_i  (st_q == ST_GAP),
    .gap_i  (gap_q),
    .zero_o (gap_zero)
  );
endmodule

// File: rtl/spi_we_checker.sv
module spi_we_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_cpol_i,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic busy_o,
  input logic sck_o,
  input logic mosi_o,
  input logic rx_valid_o
);
  logic [7:0] idle_cnt;
  logic       seen_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt  <= '0;
      seen_word <= 1'b0;
    end else begin
      if (busy_o) begin
        idle_cnt  <= '0;
        seen_word <= 1'b1;
      end else if (idle_cnt != 8'hff) begin
        idle_cnt <= idle_cnt + 8'd1;
      end
    end
  end

  assert_ready_vs_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && tx_ready_o));
  assert_accept_starts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> busy_o);
  assert_idle_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sck_o == cfg_cpol_i));
  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  assert_valid_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> rx_valid_o);
  assert_mosi_on_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && $stable(sck_o)) |-> $stable(mosi_o));
  assert_min_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_word && !busy_o && idle_cnt < 8'd9) |-> !tx_ready_o);
endmodule

bind spi_word_engine spi_we_checker i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_cpol_i (cfg_cpol_i),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .busy_o     (busy_o),
  .sck_o      (sck_o),
  .mosi_o     (mosi_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/test_spi_word_engine.sv
module test_spi_word_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_prescale = '0;
  logic [4:0]  cfg_gap = '0;
  logic [4:0]  cfg_bits = 5'd8;
  logic        cfg_cpol = 1'b1;
  logic        cfg_cpha = 1'b0;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic        miso = 1'b0;
  logic        tx_ready, rx_valid, busy, sck, mosi;
  logic [31:0] rx_data;

  int checks = 0, errors = 0, bcnt = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hace1;

  // reference model state: k = cycles since acceptance, 0 = idle
  int k = 0, m_n = 1, m_h = 1, m_g = 10;
  bit m_cpha = 1'b0;
  logic [31:0] m_word = '0, m_rx = '0;

  spi_word_engine i_spi_word_engine (
    .clk_i(clk), .rst_ni(rst_n), .cfg_prescale_i(cfg_prescale), .cfg_gap_i(cfg_gap),
    .cfg_bits_i(cfg_bits), .cfg_cpol_i(cfg_cpol), .cfg_cpha_i(cfg_cpha),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .busy_o(busy), .sck_o(sck),
    .mosi_o(mosi), .miso_i(miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso = lfsr[0];
    if (busy) bcnt++;
  end

  always @(posedge clk) begin
    if (!rst_n) k = 0;
    else begin : mdl
      int t, en;
      bit rdy;
      t = 2 * m_n * m_h;
      if (k >= 1 && k <= t && (k % m_h) == 0) begin
        en = k / m_h;
        if ((en % 2 == 0) == m_cpha) m_rx = {m_rx[30:0], miso};
      end
      rdy = (k == 0) || (k == t + m_g);
      if (rdy && tx_valid) begin
        k = 1;
        m_n = (cfg_bits == 0) ? 32 : int'(cfg_bits);
        m_h = int'(cfg_prescale) + 1;
        m_g = 4 * int'(cfg_gap) + 10;
        m_cpha = cfg_cpha;
        m_word = tx_data;
        m_rx = '0;
      end else if (k > 0) begin
        k++;
        if (k > t + m_g) k = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin : cmp
      int t, e, idx;
      logic esck, ebusy, erdy, evld;
      t = 2 * m_n * m_h;
      esck = cfg_cpol; ebusy = 1'b0; erdy = (k == 0); evld = 1'b0;
      if (k >= 1 && k <= t) begin
        ebusy = 1'b1;
        e = (k - 1) / m_h;
        esck = cfg_cpol ^ e[0];
        if (m_cpha) idx = (e == 0) ? m_n - 1 : m_n - 1 - (e - 1) / 2;
        else        idx = m_n - 1 - e / 2;
        chk(mosi == m_word[idx], "R4 mosi", {31'b0, mosi}, {31'b0, m_word[idx]});
      end else if (k > t) begin
        erdy = (k == t + m_g);
        evld = (k == t + 1);
      end
      chk(sck == esck, ebusy ? "R1 sck" : "R2 sck", {31'b0, sck}, {31'b0, esck});
      chk(busy == ebusy, "R7 busy", {31'b0, busy}, {31'b0, ebusy});
      chk(tx_ready == erdy, "R6 tx_ready", {31'b0, tx_ready}, {31'b0, erdy});
      chk(rx_valid == evld, "R5 rx_valid", {31'b0, rx_valid}, {31'b0, evld});
      if (evld) chk(rx_data == m_rx, "R3 rx_data", rx_data, m_rx);
    end
  end

  task automatic set_cfg(input int pre, input int gap, input int bits, input bit cpol, input bit cpha);
    @(posedge clk); #1;
    cfg_prescale = 8'(pre); cfg_gap = 5'(gap); cfg_bits = 5'(bits);
    cfg_cpol = cpol; cfg_cpha = cpha;
    @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic push(input logic [31:0] w);
    tx_valid = 1'b1;
    tx_data = w;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    tx_valid = 1'b0;
    while (k != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 busy", {31'b0, busy}, 32'd0);
    chk(tx_ready == 1'b1, "R9 tx_ready", {31'b0, tx_ready}, 32'd1);
    chk(rx_valid == 1'b0, "R9 rx_valid", {31'b0, rx_valid}, 32'd0);
    chk(sck == 1'b1, "R9 sck", {31'b0, sck}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    set_cfg(0, 1, 8, 1'b0, 1'b0);
    push(32'h0000_00a5); push(32'h0000_003c); wait_idle();

    set_cfg(2, 0, 16, 1'b1, 1'b1);
    push(32'h0000_8001); push(32'h0000_5a5a); push(32'h0000_ffff); wait_idle();

    set_cfg(1, 3, 0, 1'b1, 1'b0);
    push(32'hdead_beef); push(32'h1234_5678); wait_idle();

    set_cfg(0, 31, 1, 1'b0, 1'b1);
    push(32'h0000_0001); push(32'h0000_0000); wait_idle();

    set_cfg(3, 2, 5, 1'b0, 1'b1);
    push(32'h0000_0013); wait_idle();
    set_cfg(0, 2, 5, 1'b1, 1'b0);
    push(32'h0000_000c); wait_idle();

    // R8: settings altered mid-word must not affect the running word
    set_cfg(1, 1, 8, 1'b0, 1'b0);
    bcnt = 0;
    push(32'h0000_00c3);
    tx_valid = 1'b0;
    set_cfg(5, 20, 3, 1'b0, 1'b1);
    wait_idle();
    chk(bcnt == 32, "R8 busy length", 32'(bcnt), 32'd32);

    finish_run();
  end
endmodule